// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

A memory-mapped timekeeping peripheral. A 32-bit seconds count advances once per second. The second is produced by a prescaler that counts pulses of a slow reference clock-enable input. A 32-bit alarm compare value raises an alarm flag on the second at which the count reaches it. A per-second flag is raised on every second. Each flag has its own interrupt enable, and a single interrupt output combines them.

Software reaches the block through a flat 32-bit register bus. Reads are combinational. Writes model a slow backing domain: once a write is accepted, the ready bit in the control register drops for a fixed number of cycles. Any write issued while it is low is discarded, so software polls the ready bit before each write. The event flags are cleared by writing 0 to their bits and kept by writing 1, which lets a read-modify-write of control pass pending events through untouched.

A scratchpad word keeps its contents, so boot code can look for a signature to tell a first power-up from a warm start. Writing the value 1 to the hibernate word raises a power-down request. The seconds count can change between two reads, so software reads it until two successive values agree.

Top module: `secs_rtc`

## Requirements
- R1: After reset the control word reads 0x0000_0080, where bit 7 is write-ready and every other bit is 0. The seconds (offset 0x04), alarm (0x08), hibernate (0x20) and scratchpad (0x34) words read 0, and `irq` and `hib_req` are 0. Control is at offset 0x00. Its fields are: bit 0 count enable, bit 2 alarm enable, bit 3 alarm interrupt enable, bit 4 alarm flag, bit 5 per-second interrupt enable, bit 6 per-second flag, bit 7 write-ready (read-only). Bit 1 and bits 31:8 read 0.
- R2: A write accepted at a clock edge drives write-ready (control bit 7) low for exactly WR_HOLD following cycles. A write presented while write-ready is low changes no register.
- R3: While count enable is 1, the seconds count rises by one, wrapping modulo 2^32, on every PRESC-th cycle with `ref_en` high. While count enable is 0 the count holds and the prescaler returns to zero, so after re-enabling a full PRESC pulses are needed for the next step.
- R4: The seconds word is writable with any 32-bit value, including 0, and the written value is read back from the next cycle onward.
- R5: The per-second flag (control bit 6) is set on every seconds step.
- R6: The alarm flag (control bit 4) is set on the step whose new seconds value equals the alarm word, and only while alarm enable (bit 2) is 1.
- R7: Writing 0 to a flag bit clears that flag, writing 1 leaves it as it was, and both flags can be cleared by a single control write.
- R8: `irq` is high exactly when (per-second flag AND per-second interrupt enable) OR (alarm flag AND alarm interrupt enable).
- R9: Writing the value 1 to the hibernate word sets `hib_req`, which stays set and reads back as bit 0 of that word. Writing any other value there has no effect.
- R10: The scratchpad word reads back the last accepted write to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference clock-enable pulse counted by the prescaler |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt request |
| hib_req | output | 1 | Power-down request |

## Verification
The assertions assume that `ref_en` and the bus inputs change only away from the rising edge. They also assume that a seconds write and a second step never fall in the same cycle, since the write then takes priority. The stimulus keeps `ref_en` low during every bus write and changes all inputs on the falling edge. It polls write-ready before each write, except for the single probe that deliberately writes into the busy window. The prescaler phase is tracked in the bench by counting the pulses it issues, so every expected seconds value follows from that count.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam int DW = 32;
  localparam int AW = 8;

  localparam logic [AW-1:0] OFF_CTRL  = 8'h00;
  localparam logic [AW-1:0] OFF_SECS  = 8'h04;
  localparam logic [AW-1:0] OFF_ALARM = 8'h08;
  localparam logic [AW-1:0] OFF_HIB   = 8'h20;
  localparam logic [AW-1:0] OFF_SCR   = 8'h34;

  localparam int B_EN  = 0;
  localparam int B_AE  = 2;
  localparam int B_AIE = 3;
  localparam int B_AF  = 4;
  localparam int B_SIE = 5;
  localparam int B_SF  = 6;
  localparam int B_RDY = 7;

  typedef struct packed {
    logic sf;
    logic sie;
    logic af;
    logic aie;
    logic ae;
    logic en;
  } rtc_ctl_t;

  function automatic logic [DW-1:0] f_next_secs(input logic [DW-1:0] s);
    return s + 1'b1;
  endfunction

  function automatic logic f_irq(input rtc_ctl_t c);
    return (c.sf & c.sie) | (c.af & c.aie);
  endfunction

  function automatic logic [DW-1:0] f_ctrl_word(input rtc_ctl_t c, input logic rdy);
    logic [DW-1:0] w;
    w        = '0;
    w[B_EN]  = c.en;
    w[B_AE]  = c.ae;
    w[B_AIE] = c.aie;
    w[B_AF]  = c.af;
    w[B_SIE] = c.sie;
    w[B_SF]  = c.sf;
    w[B_RDY] = rdy;
    return w;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign tick    = run && ref_en && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (ref_en) cnt <= at_last ? '0 : cnt + 1'b1;
  end

  // R3: a stopped prescaler is back at zero one cycle later
  a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
  // R3: without a reference pulse the phase does not move
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ref_en) |=> $stable(cnt));
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  output logic accept,
  output logic rdy
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic [HW-1:0] busy;

  assign rdy    = (busy == '0);
  assign accept = we && rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy <= '0;
    else if (accept)     busy <= HOLD_V;
    else if (busy != '0) busy <= busy - 1'b1;
  end

  // R2: an accepted write always closes the window
  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rdy);
  // R2: ready comes back only by counting down, never by a new write
  a_r2_reopen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> !$past(accept));
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import secs_rtc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_ctrl,
  input  logic          wr_secs,
  input  logic          wr_alarm,
  input  logic [DW-1:0] wdata,
  output rtc_ctl_t      ctl,
  output logic [DW-1:0] secs,
  output logic [DW-1:0] alarm
);
  logic [DW-1:0] secs_inc;
  logic          sf_set;
  logic          af_set;
  logic          sf_keep;
  logic          af_keep;

  assign secs_inc = f_next_secs(secs);
  assign sf_set   = tick;
  assign af_set   = tick && ctl.ae && (secs_inc == alarm);
  assign sf_keep  = wr_ctrl ? (ctl.sf & wdata[B_SF]) : ctl.sf;
  assign af_keep  = wr_ctrl ? (ctl.af & wdata[B_AF]) : ctl.af;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl   <= '0;
      secs  <= '0;
      alarm <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl.sie <= wdata[B_SIE];
        ctl.aie <= wdata[B_AIE];
        ctl.ae  <= wdata[B_AE];
        ctl.en  <= wdata[B_EN];
      end
      ctl.sf <= sf_keep | sf_set;
      ctl.af <= af_keep | af_set;
      if (wr_secs)   secs <= wdata;
      else if (tick) secs <= secs_inc;
      if (wr_alarm)  alarm <= wdata;
    end
  end

  // R3: a step moves the count by exactly one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_secs) |=> (secs == $past(secs) + 1'b1));
  // R3: no step and no write leaves the count alone
  a_r3_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_secs) |=> $stable(secs));
  // R4: a written value lands on the next cycle
  a_r4_secs_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_secs |=> (secs == $past(wdata)));
  // R6: the alarm flag rises only while alarm enable was on
  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.af) |-> $past(ctl.ae));
  // R7: a flag survives any cycle without a control write
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.af && !wr_ctrl) |=> ctl.af);
  // R5: per-second flag only rises on a step
  a_r5_sf_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.sf) |-> $past(tick));
endmodule

// File: rtl/secs_rtc.sv
module secs_rtc
  import secs_rtc_pkg::*;
#(
  parameter int PRESC   = 32768,
  parameter int WR_HOLD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          hib_req
);
  logic          accept;
  logic          wr_rdy;
  logic          tick;
  logic          wr_ctrl, wr_secs, wr_alarm, wr_hib, wr_scr;
  rtc_ctl_t      ctl;
  logic [DW-1:0] secs;
  logic [DW-1:0] alarm;
  logic [DW-1:0] scratch;
  logic          hib_q;

  rtc_wr_gate #(.HOLD(WR_HOLD)) u_gate (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .accept(accept), .rdy(wr_rdy)
  );

  rtc_prescaler #(.DIV(PRESC)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(ctl.en), .ref_en(ref_en), .tick(tick)
  );

  assign wr_ctrl  = accept && (bus_addr == OFF_CTRL);
  assign wr_secs  = accept && (bus_addr == OFF_SECS);
  assign wr_alarm = accept && (bus_addr == OFF_ALARM);
  assign wr_hib   = accept && (bus_addr == OFF_HIB);
  assign wr_scr   = accept && (bus_addr == OFF_SCR);

  rtc_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_ctrl(wr_ctrl), .wr_secs(wr_secs), .wr_alarm(wr_alarm),
    .wdata(bus_wdata), .ctl(ctl), .secs(secs), .alarm(alarm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch <= '0;
      hib_q   <= 1'b0;
    end else begin
      if (wr_scr) scratch <= bus_wdata;
      if (wr_hib && (bus_wdata == DW'(1))) hib_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL:  bus_rdata = f_ctrl_word(ctl, wr_rdy);
      OFF_SECS:  bus_rdata = secs;
      OFF_ALARM: bus_rdata = alarm;
      OFF_HIB:   bus_rdata = {{(DW-1){1'b0}}, hib_q};
      OFF_SCR:   bus_rdata = scratch;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq     = f_irq(ctl);
  assign hib_req = hib_q;

  // R9: the power-down request never drops once raised
  a_r9_hib_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hib_req |=> hib_req);
  // R9: it rises only after a write of 1 to the hibernate word
  a_r9_hib_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hib_req) |-> $past(wr_hib && (bus_wdata == DW'(1))));
  // R10: scratchpad changes only through its own write
  a_r10_scr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_scr |=> $stable(scratch));
  // R8: with both enables off no interrupt can be raised
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.sie && !ctl.aie) |-> !irq);
endmodule

// File: tb/secs_rtc_tb.sv
module secs_rtc_tb;
  localparam int P    = 4;
  localparam int HOLD = 4;
  localparam logic [7:0] A_CTRL = 8'h00, A_SECS = 8'h04, A_ALRM = 8'h08,
                         A_HIB = 8'h20, A_SCR = 8'h34;
  localparam logic [31:0] EN = 32'h1, AE = 32'h4, AIE = 32'h8, AF = 32'h10,
                          SIE = 32'h20, SF = 32'h40, RDY = 32'h80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_en = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, hib_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  secs_rtc #(.PRESC(P), .WR_HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .hib_req(hib_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] c;
    for (int i = 0; i < 50; i++) begin
      rd(A_CTRL, c);
      if (c[7]) break;
    end
    wr_raw(a, d);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_en = 1'b1;
      @(negedge clk); ref_en = 1'b0;
    end
  endtask

  function automatic logic [31:0] flags(input logic [31:0] c);
    return c & (SF | AF);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] bases [3];
    int low;
    bases[0] = 32'h0; bases[1] = 32'h0000_1234; bases[2] = 32'hFFFF_FFFE;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, RDY);
    rd(A_SECS, v); chk("R1 secs", v, 0);
    rd(A_ALRM, v); chk("R1 alarm", v, 0);
    rd(A_HIB, v);  chk("R1 hib", v, 0);
    rd(A_SCR, v);  chk("R1 scratch", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 hib_req", {31'b0, hib_req}, 0);

    // R2 ready low for HOLD cycles after an accepted write
    wr(A_SCR, 32'h1234_5678);
    low = 0;
    bus_addr = A_CTRL;
    #1;
    for (int i = 0; i < 20; i++) begin
      if (bus_rdata[7]) break;
      low++;
      @(negedge clk); #1;
    end
    chk("R2 busy cycles", low, HOLD);
    // R10 scratchpad keeps the value
    rd(A_SCR, v); chk("R10 scratch", v, 32'h1234_5678);
    // R2 write inside the busy window is dropped
    wr(A_SCR, 32'h0BAD_0001);
    wr_raw(A_SCR, 32'hDEAD_BEEF);
    rd(A_CTRL, v); chk("R2 still busy", v & RDY, 0);
    repeat (HOLD + 2) @(negedge clk);
    rd(A_SCR, v); chk("R2 ignored write", v, 32'h0BAD_0001);
    wr(A_SECS, 32'h55);
    wr_raw(A_SECS, 32'h77);
    repeat (HOLD + 2) @(negedge clk);
    rd(A_SECS, v); chk("R2 ignored secs write", v, 32'h55);

    // R3/R4 counting sweep from several bases, including wrap
    foreach (bases[b]) begin
      wr(A_CTRL, SF | AF);            // disable, keep flags, prescaler to 0
      wr(A_SECS, bases[b]);
      rd(A_SECS, v); chk("R4 secs write", v, bases[b]);
      wr(A_CTRL, EN | SF | AF);
      for (int k = 1; k <= 3 * P + 1; k++) begin
        pulses(1);
        rd(A_SECS, v); chk("R3 count", v, bases[b] + 32'(k / P));
      end
    end
    // R3 enable off: holds, and prescaler restarts
    wr(A_CTRL, SF | AF);
    rd(A_SECS, v);
    begin
      logic [31:0] held;
      held = v;
      pulses(2 * P);
      rd(A_SECS, v); chk("R3 hold while off", v, held);
      wr(A_CTRL, EN | SF | AF);
      pulses(P - 1);
      rd(A_SECS, v); chk("R3 restart partial", v, held);
      pulses(1);
      rd(A_SECS, v); chk("R3 restart step", v, held + 1);
    end

    // R5 per-second flag set, R8 irq with its enable
    rd(A_CTRL, v); chk("R5 sf set", v & SF, SF);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(A_CTRL, EN | SIE | SF | AF);
    @(negedge clk);
    chk("R8 irq sf", {31'b0, irq}, 1);
    // R7 clear both flags in one write (counter on, no pulses)
    wr(A_CTRL, EN | SIE);
    rd(A_CTRL, v); chk("R7 both cleared", flags(v), 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);

    // R6 alarm on matching step
    wr(A_SECS, 32'd10);
    wr(A_ALRM, 32'd12);
    wr(A_CTRL, EN | AE | AIE);
    pulses(P);
    rd(A_CTRL, v); chk("R6 no early alarm", v & AF, 0);
    chk("R5 sf next step", v & SF, SF);
    wr(A_CTRL, EN | AE | AIE);        // clear sf
    pulses(P);
    rd(A_SECS, v); chk("R6 secs at alarm", v, 32'd12);
    rd(A_CTRL, v); chk("R6 alarm flag", v & AF, AF);
    chk("R8 irq alarm", {31'b0, irq}, 1);
    // R7 writing 1 keeps, writing 0 clears
    wr(A_CTRL, EN | AE | AIE | AF | SF);
    rd(A_CTRL, v); chk("R7 write one keeps", flags(v), AF | SF);
    wr(A_CTRL, EN | AE | AIE | SF);
    rd(A_CTRL, v); chk("R7 write zero clears af", flags(v), SF);
    chk("R8 irq af cleared", {31'b0, irq}, 0);
    // R6 no alarm while alarm enable is 0
    wr(A_CTRL, EN | AIE);
    wr(A_ALRM, 32'd14);
    pulses(2 * P);
    rd(A_SECS, v); chk("R6 secs reach", v, 32'd14);
    rd(A_CTRL, v); chk("R6 disabled alarm", v & AF, 0);
    chk("R8 irq none", {31'b0, irq}, 0);

    // R9 hibernate
    wr(A_HIB, 32'd2);
    @(negedge clk);
    chk("R9 other value", {31'b0, hib_req}, 0);
    wr(A_HIB, 32'd1);
    @(negedge clk);
    chk("R9 request", {31'b0, hib_req}, 1);
    rd(A_HIB, v); chk("R9 readback", v, 1);
    wr(A_HIB, 32'd0);
    @(negedge clk);
    chk("R9 sticky", {31'b0, hib_req}, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule